// File: doc/BRIEF.md
# Memory Data Register Bus Interface

This block sits between a processor's internal data bus and an external memory bus. It holds a memory address register, which drives the address lines at all times, and a memory data register. The data register has four separate enables. Two face the internal bus: load from it and drive onto it. Two face the memory: capture from the read data lines and drive onto the write data lines.

A control unit starts a read or a write with a one-cycle request pulse. The block raises the matching memory strobe and holds it until the memory raises its completion input. The strobe then drops on the next edge. The memory may take any number of cycles to respond, so no transfer ends after a fixed latency. During a wait step the block gives the control unit a stall output that freezes its step counter until completion arrives. While a transfer is outstanding, the block ignores new requests and shows a busy flag.

Top module: `mdr_bus_if`

## Requirements
- R1: After reset the address register and the data register hold 0, both memory strobes are low and busy is low.
- R2: When the address-load enable is high at a clock edge, the address register takes the low AW bits of the internal bus. The address lines show this value from that edge onward. Without the enable the register holds its value.
- R3: A read request while idle raises the read strobe and busy at the next edge. Both stay high through every cycle in which completion is low. They fall at the edge that follows the first cycle with completion high.
- R4: A write request while idle drives the write strobe in the same way. If read and write are requested in the same idle cycle, the read is taken and the write strobe stays low.
- R5: A read or write request made while busy is ignored. The strobe that is active stays unchanged, and the other strobe stays low.
- R6: When the memory-capture enable is high in a cycle with a read outstanding and completion high, the data register takes the read data lines at that edge. Read data shown in earlier wait cycles is not kept.
- R7: When the internal-load enable is high, the data register takes the internal bus, unless a memory capture happens at the same edge. In that case the memory data wins.
- R8: The internal-bus output equals the data register while the internal-drive enable is high, with its output-enable high. Otherwise both are 0.
- R9: The write data lines equal the data register while the memory-drive enable is high, with its output-enable high. Otherwise both are 0.
- R10: The stall output is high exactly when the wait-step input is high and completion is low, in the same cycle.
- R11: Completion together with the memory-capture enable has no effect on the data register when no read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ibus_i | input | DW | Internal bus value seen by the block |
| ibus_o | output | DW | Data register value driven toward the internal bus |
| ibus_oe_o | output | 1 | Internal bus drive enable |
| addr_ld_i | input | 1 | Load address register from internal bus |
| dat_ld_int_i | input | 1 | Load data register from internal bus |
| dat_drv_int_i | input | 1 | Drive data register onto internal bus |
| dat_cap_mem_i | input | 1 | Capture read data into data register on completion |
| dat_drv_mem_i | input | 1 | Drive data register onto memory write lines |
| rd_req_i | input | 1 | Read request pulse |
| wr_req_i | input | 1 | Write request pulse |
| wait_step_i | input | 1 | Control step waits for completion |
| mem_addr_o | output | AW | Memory address lines |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | DW | Memory read data lines |
| mem_wdata_o | output | DW | Memory write data lines |
| mem_wdata_oe_o | output | 1 | Write data drive enable |
| mem_done_i | input | 1 | Memory function completed |
| stall_o | output | 1 | Freeze the control step counter |
| busy_o | output | 1 | Transfer outstanding |

## Verification
Reads and writes run with completion latencies from zero to four cycles and several data and address values. This separates a correct wait-until-completion strobe from one that uses a fixed delay. During each wait the read lines show different data, so a capture made on the wrong cycle is seen. Stray requests of the opposite kind, simultaneous read and write requests, an internal load that competes with a memory capture, and completion with no read outstanding each exercise one of the priority and ignore rules.

// File: rtl/mdr_bus_pkg.sv
package mdr_bus_pkg;
  typedef enum logic [1:0] {
    XFER_IDLE  = 2'd0,
    XFER_READ  = 2'd1,
    XFER_WRITE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/mdr_addr_reg.sv
module mdr_addr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q_o;
    if (ld_i) q_next = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_next;
  end

  // R2: address register loads and holds
  a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> q_o == $past(d_i));
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/mdr_data_reg.sv
module mdr_data_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mem_i,
  input  logic         ld_int_i,
  input  logic [W-1:0] mem_d_i,
  input  logic [W-1:0] int_d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q_o;
    if (cap_mem_i)     q_next = mem_d_i;
    else if (ld_int_i) q_next = int_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_next;
  end

  // R6: memory capture takes the read lines
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mem_i |=> q_o == $past(mem_d_i));
  // R7: internal load when no capture competes
  a_r7_int_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_int_i && !cap_mem_i) |=> q_o == $past(int_d_i));
endmodule

// File: rtl/mdr_xfer_ctrl.sv
module mdr_xfer_ctrl
  import mdr_bus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic done_i,
  output logic rd_o,
  output logic wr_o,
  output logic busy_o,
  output logic rd_done_o
);
  xfer_state_e state_q, state_next;

  always_comb begin
    state_next = state_q;
    unique case (state_q)
      XFER_IDLE: begin
        if (rd_req_i)      state_next = XFER_READ;
        else if (wr_req_i) state_next = XFER_WRITE;
      end
      XFER_READ, XFER_WRITE: begin
        if (done_i) state_next = XFER_IDLE;
      end
      default: state_next = XFER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= XFER_IDLE;
    else        state_q <= state_next;
  end

  assign rd_o      = (state_q == XFER_READ);
  assign wr_o      = (state_q == XFER_WRITE);
  assign busy_o    = (state_q != XFER_IDLE);
  assign rd_done_o = rd_o && done_i;

  // R3: strobe held until completion, then dropped
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> busy_o);
  a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i) |=> !busy_o);
  // R4: read wins over write from idle; strobes never both high
  a_r4_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && rd_req_i) |=> (rd_o && !wr_o));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_o, wr_o}));
  // R5: requests while busy do not change the strobes
  a_r5_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> $stable({rd_o, wr_o}));
endmodule

// File: rtl/mdr_bus_if.sv
module mdr_bus_if #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ibus_i,
  output logic [DW-1:0] ibus_o,
  output logic          ibus_oe_o,
  input  logic          addr_ld_i,
  input  logic          dat_ld_int_i,
  input  logic          dat_drv_int_i,
  input  logic          dat_cap_mem_i,
  input  logic          dat_drv_mem_i,
  input  logic          rd_req_i,
  input  logic          wr_req_i,
  input  logic          wait_step_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_wdata_oe_o,
  input  logic          mem_done_i,
  output logic          stall_o,
  output logic          busy_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  logic                   rd_done;
  logic                   cap_now;
  logic [DW-1:0]          dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  mdr_addr_reg #(.W(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ld_i  (addr_ld_i),
    .d_i   (ibus_i[AW-1:0]),
    .q_o   (mem_addr_o)
  );

  mdr_xfer_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rd_req_i  (rd_req_i),
    .wr_req_i  (wr_req_i),
    .done_i    (mem_done_i),
    .rd_o      (mem_rd_o),
    .wr_o      (mem_wr_o),
    .busy_o    (busy_o),
    .rd_done_o (rd_done)
  );

  assign cap_now = dat_cap_mem_i && rd_done;

  mdr_data_reg #(.W(DW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cap_mem_i (cap_now),
    .ld_int_i  (dat_ld_int_i),
    .mem_d_i   (mem_rdata_i),
    .int_d_i   (ibus_i),
    .q_o       (dat_q)
  );

  assign ibus_o         = dat_drv_int_i ? dat_q : '0;
  assign ibus_oe_o      = dat_drv_int_i;
  assign mem_wdata_o    = dat_drv_mem_i ? dat_q : '0;
  assign mem_wdata_oe_o = dat_drv_mem_i;
  assign stall_o        = wait_step_i && !mem_done_i;

  // R11: completion with no read outstanding leaves the data register alone
  a_r11_no_stray_capture: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!mem_rd_o && !dat_ld_int_i) |=> $stable(dat_q));
endmodule

// File: tb/mdr_bus_if_tb.sv
module mdr_bus_if_tb;
  localparam int DW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] ibus_i;
  logic [DW-1:0] ibus_o;
  logic          ibus_oe_o;
  logic          addr_ld_i, dat_ld_int_i, dat_drv_int_i, dat_cap_mem_i, dat_drv_mem_i;
  logic          rd_req_i, wr_req_i, wait_step_i;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o, mem_wr_o;
  logic [DW-1:0] mem_rdata_i;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_wdata_oe_o;
  logic          mem_done_i;
  logic          stall_o, busy_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mdr_bus_if #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ibus_i(ibus_i), .ibus_o(ibus_o), .ibus_oe_o(ibus_oe_o),
    .addr_ld_i(addr_ld_i), .dat_ld_int_i(dat_ld_int_i), .dat_drv_int_i(dat_drv_int_i),
    .dat_cap_mem_i(dat_cap_mem_i), .dat_drv_mem_i(dat_drv_mem_i),
    .rd_req_i(rd_req_i), .wr_req_i(wr_req_i), .wait_step_i(wait_step_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_rdata_i(mem_rdata_i), .mem_wdata_o(mem_wdata_o), .mem_wdata_oe_o(mem_wdata_oe_o),
    .mem_done_i(mem_done_i), .stall_o(stall_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    addr_ld_i = 0; dat_ld_int_i = 0; dat_drv_int_i = 0; dat_cap_mem_i = 0;
    dat_drv_mem_i = 0; rd_req_i = 0; wr_req_i = 0; wait_step_i = 0;
    mem_done_i = 0; ibus_i = '0; mem_rdata_i = '0;
  endtask

  task automatic do_read(input int lat, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    @(negedge clk);
    idle_inputs();
    ibus_i = addr; addr_ld_i = 1; rd_req_i = 1;
    @(posedge clk); #1;
    check("R2 addr", mem_addr_o, addr);
    check("R3 rd high", mem_rd_o, 1);
    check("R3 busy", busy_o, 1);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      idle_inputs();
      dat_cap_mem_i = 1; wait_step_i = 1; mem_rdata_i = ~data;
      wr_req_i = 1; rd_req_i = (k == 1);
      #1;
      check("R10 stall high", stall_o, 1);
      @(posedge clk); #1;
      check("R3 rd held", mem_rd_o, 1);
      check("R5 no wr", mem_wr_o, 0);
    end
    @(negedge clk);
    idle_inputs();
    dat_cap_mem_i = 1; wait_step_i = 1; mem_done_i = 1; mem_rdata_i = data;
    dat_ld_int_i = 1; ibus_i = data ^ 8'h5A;
    #1;
    check("R10 stall low", stall_o, 0);
    @(posedge clk); #1;
    check("R3 rd drop", mem_rd_o, 0);
    check("R3 busy drop", busy_o, 0);
    @(negedge clk);
    idle_inputs();
    dat_drv_int_i = 1;
    #1;
    check("R6 R7 captured", ibus_o, data);
    check("R8 oe", ibus_oe_o, 1);
  endtask

  task automatic do_write(input int lat, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    @(negedge clk);
    idle_inputs();
    ibus_i = addr; addr_ld_i = 1;
    @(posedge clk); #1;
    check("R2 addr", mem_addr_o, addr);
    @(negedge clk);
    idle_inputs();
    ibus_i = data; dat_ld_int_i = 1; wr_req_i = 1;
    @(posedge clk); #1;
    check("R4 wr high", mem_wr_o, 1);
    check("R2 addr hold", mem_addr_o, addr);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      idle_inputs();
      dat_drv_mem_i = 1; wait_step_i = 1; rd_req_i = 1;
      #1;
      check("R9 wdata", mem_wdata_o, data);
      check("R10 stall high", stall_o, 1);
      @(posedge clk); #1;
      check("R4 wr held", mem_wr_o, 1);
      check("R5 no rd", mem_rd_o, 0);
    end
    @(negedge clk);
    idle_inputs();
    dat_drv_mem_i = 1; wait_step_i = 1; mem_done_i = 1;
    #1;
    check("R9 wdata oe", mem_wdata_oe_o, 1);
    check("R10 stall low", stall_o, 0);
    @(posedge clk); #1;
    check("R4 wr drop", mem_wr_o, 0);
    @(negedge clk);
    idle_inputs();
    #1;
    check("R9 wdata off", mem_wdata_o, 0);
    check("R8 ibus off", ibus_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 addr", mem_addr_o, 0);
    check("R1 rd", mem_rd_o, 0);
    check("R1 wr", mem_wr_o, 0);
    check("R1 busy", busy_o, 0);
    @(negedge clk);
    dat_drv_int_i = 1; #1;
    check("R1 data", ibus_o, 0);

    for (int lat = 0; lat < 5; lat++) begin
      for (int i = 0; i < 4; i++) begin
        logic [7:0] a, d;
        a = 8'(lat * 37 + i * 71 + 3);
        d = 8'(lat * 53 + i * 29 + 17);
        do_read(lat, a, d);
        do_write(lat, ~a, ~d);
      end
    end

    // R4: simultaneous requests, read wins
    @(negedge clk);
    idle_inputs();
    rd_req_i = 1; wr_req_i = 1;
    @(posedge clk); #1;
    check("R4 rd wins", mem_rd_o, 1);
    check("R4 wr low", mem_wr_o, 0);
    @(negedge clk);
    idle_inputs();
    mem_done_i = 1;
    @(posedge clk); #1;
    check("R3 idle again", busy_o, 0);

    // R11: stray completion with capture enabled while idle
    do_read(1, 8'h10, 8'hC3);
    @(negedge clk);
    idle_inputs();
    mem_done_i = 1; dat_cap_mem_i = 1; mem_rdata_i = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    dat_drv_int_i = 1; #1;
    check("R11 data kept", ibus_o, 8'hC3);

    // R2: no load holds address
    @(negedge clk);
    idle_inputs();
    ibus_i = 8'hEE;
    @(posedge clk); #1;
    check("R2 addr hold", mem_addr_o, 8'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule